// File: doc/BRIEF.md
# Two-Channel Burst PWM Generator

This block drives two pulse-width-modulated lines. Each channel has its own high period, low period and burst length. Periods are counted in ticks of a shared timebase. The block divides the system clock down to that tick itself; by default the tick comes every 100 µs. A host writes configuration values through a simple write strobe carrying a one-byte code and a 16-bit data word. A shared enable mask turns channels on and off.

Once enabled, a channel alternates high and low phases. With a non-zero burst length it stops after that many high/low cycles and rests low. With a burst length of zero it runs until it is disabled. The intended use is to clear a channel's enable bit, load its periods and burst length, and then set the bit again. The periods, burst length and mask are 16-bit and 2-bit registers inside the block.

Top module: `burst_pwm_top`

## Requirements
- R1: `tickOut` pulses high for exactly one clock cycle every ClkHz/TickHz clock cycles. The first pulse comes ClkHz/TickHz cycles after reset is released.
- R2: Writes are decoded from `wrCode`:
  - 0x10+2n loads the high period of channel n.
  - 0x11+2n loads the low period of channel n.
  - 0x14+n loads the burst length of channel n.
  - 0x1F loads the enable mask, with bit n enabling channel n.
  - The mask appears on `enableMask` in the cycle after the write, and it changes only on such a write.
- R3: When a mask write changes bit n from 0 to 1, channel n starts a fresh cycle. In the cycle after the write, `pwmOut[n]` and `running[n]` are both 1.
- R4: Counting tick pulses from the enable, the output is high for exactly `hi` ticks and then low for exactly `lo` ticks. It changes only on a tick, an enable or a disable.
- R5: With a burst length N greater than 0, the channel stops after N complete high/low cycles. `pwmOut[n]` and `running[n]` then stay 0 even though mask bit n is still set.
- R6: With a burst length of 0, the channel repeats high/low cycles without end.
- R7: A high or low period of 0 behaves as a period of 1.
- R8: When a mask write clears bit n, `pwmOut[n]` and `running[n]` are 0 in the next cycle, even in the middle of a phase. A disabled channel stays low.
- R9: A mask write that leaves bit n set does not restart or disturb channel n's ongoing sequence.
- R10: The two channels run independently when enabled by the same write, each with its own periods and burst length.
- R11: After a burst has finished, clearing and then setting the enable bit runs the burst again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrCode | input | 8 | Register code of the write |
| wrData | input | 16 | Write data |
| pwmOut | output | 2 | PWM output lines, bit n for channel n |
| running | output | 2 | Channel n is producing its sequence |
| enableMask | output | 2 | Current enable mask, readable back |
| tickOut | output | 1 | Timebase tick, one cycle wide |

## Verification
The waveform is checked tick by tick against a closed formula of period position and cycle number, using several patterns:
- Asymmetric periods separate the high count from the low count.
- A finite burst shows that the cycle count stops at the right place.
- A zero burst length tells continuous running apart from an early stop.
- Zero periods exercise the clamp.

Running both channels from one mask write with different settings exposes any crosstalk between them. Rewriting an already set mask bit mid-sequence would expose a restart where none belongs. A mid-phase disable and a re-enable after completion show the stop and restart paths.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;
  localparam int NumCh = 2;
  localparam int PerW  = 16;
  localparam int CodeW = 8;

  localparam logic [CodeW-1:0] CodeHiBase    = 8'h10;
  localparam logic [CodeW-1:0] CodeLoBase    = 8'h11;
  localparam logic [CodeW-1:0] CodeBurstBase = 8'h14;
  localparam logic [CodeW-1:0] CodeEnable    = 8'h1F;

  typedef struct packed {
    logic             tick;
    logic [NumCh-1:0] start;
    logic [NumCh-1:0] stop;
    logic [NumCh-1:0] wrHi;
    logic [NumCh-1:0] wrLo;
    logic [NumCh-1:0] wrBurst;
    logic [PerW-1:0]  data;
  } pwmStrobes_t;
endpackage

// File: rtl/burst_pwm_ctrl.sv
module burst_pwm_ctrl
  import burst_pwm_pkg::*;
#(
  parameter int ClkHz  = 50_000_000,
  parameter int TickHz = 10_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CodeW-1:0] wrCode,
  input  logic [PerW-1:0]  wrData,
  output pwmStrobes_t      strobes,
  output logic [NumCh-1:0] enMask
);
  localparam int Div   = ClkHz / TickHz;
  localparam int TickW = (Div > 2) ? $clog2(Div) : 1;

  logic [TickW-1:0] tickCnt;
  logic             tickNow;
  logic             maskWr;

  assign tickNow = (tickCnt == TickW'(Div - 1));

  always_ff @(posedge clk) begin
    if (!rstN)        tickCnt <= '0;
    else if (tickNow) tickCnt <= '0;
    else              tickCnt <= tickCnt + TickW'(1);
  end

  assign maskWr = wrEn && (wrCode == CodeEnable);

  always_ff @(posedge clk) begin
    if (!rstN)       enMask <= '0;
    else if (maskWr) enMask <= wrData[NumCh-1:0];
  end

  for (genvar n = 0; n < NumCh; n++) begin : gDecode
    localparam logic [CodeW-1:0] HiCode    = CodeHiBase + CodeW'(2 * n);
    localparam logic [CodeW-1:0] LoCode    = CodeLoBase + CodeW'(2 * n);
    localparam logic [CodeW-1:0] BurstCode = CodeBurstBase + CodeW'(n);
    assign strobes.wrHi[n]    = wrEn && (wrCode == HiCode);
    assign strobes.wrLo[n]    = wrEn && (wrCode == LoCode);
    assign strobes.wrBurst[n] = wrEn && (wrCode == BurstCode);
    assign strobes.start[n]   = maskWr && wrData[n] && !enMask[n];
    assign strobes.stop[n]    = maskWr && !wrData[n] && enMask[n];
  end

  assign strobes.tick = tickNow;
  assign strobes.data = wrData;

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick |=> !strobes.tick); // R1
  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    maskWr |=> (enMask == $past(wrData[NumCh-1:0]))); // R2
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !maskWr |=> $stable(enMask)); // R2
endmodule

// File: rtl/burst_pwm_datapath.sv
module burst_pwm_datapath
  import burst_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobes_t      strobes,
  output logic [NumCh-1:0] pwmOut,
  output logic [NumCh-1:0] running
);
  for (genvar n = 0; n < NumCh; n++) begin : gCh
    logic [PerW-1:0] hiReg, loReg, burstReg;
    logic [PerW-1:0] hiEff, loEff;
    logic [PerW-1:0] phaseCnt, cycCnt;
    logic            isHigh, run;
    logic            lastCycle;

    assign hiEff     = (hiReg == '0) ? PerW'(1) : hiReg;
    assign loEff     = (loReg == '0) ? PerW'(1) : loReg;
    assign lastCycle = (burstReg != '0) && ((cycCnt + PerW'(1)) == burstReg);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiReg    <= '0;
        loReg    <= '0;
        burstReg <= '0;
      end else begin
        if (strobes.wrHi[n])    hiReg    <= strobes.data;
        if (strobes.wrLo[n])    loReg    <= strobes.data;
        if (strobes.wrBurst[n]) burstReg <= strobes.data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        run      <= 1'b0;
        isHigh   <= 1'b0;
        phaseCnt <= '0;
        cycCnt   <= '0;
      end else if (strobes.stop[n]) begin
        run    <= 1'b0;
        isHigh <= 1'b0;
      end else if (strobes.start[n]) begin
        run      <= 1'b1;
        isHigh   <= 1'b1;
        phaseCnt <= hiEff;
        cycCnt   <= '0;
      end else if (run && strobes.tick) begin
        if (phaseCnt != PerW'(1)) begin
          phaseCnt <= phaseCnt - PerW'(1);
        end else if (isHigh) begin
          isHigh   <= 1'b0;
          phaseCnt <= loEff;
        end else if (lastCycle) begin
          run <= 1'b0;
        end else begin
          isHigh   <= 1'b1;
          phaseCnt <= hiEff;
          cycCnt   <= cycCnt + PerW'(1);
        end
      end
    end

    assign pwmOut[n]  = run && isHigh;
    assign running[n] = run;

    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      strobes.start[n] |=> (pwmOut[n] && running[n])); // R3
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rstN)
      strobes.stop[n] |=> (!pwmOut[n] && !running[n])); // R8
    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.tick && !strobes.start[n] && !strobes.stop[n]) |=> $stable(pwmOut[n])); // R4
    AST_PHASE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
      run |-> (phaseCnt != '0)); // R7
    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
      (run && burstReg != '0) |-> (cycCnt < burstReg)); // R5
  end
endmodule

// File: rtl/burst_pwm_top.sv
module burst_pwm_top
  import burst_pwm_pkg::*;
#(
  parameter int ClkHz  = 50_000_000,
  parameter int TickHz = 10_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrCode,
  input  logic [15:0] wrData,
  output logic [1:0]  pwmOut,
  output logic [1:0]  running,
  output logic [1:0]  enableMask,
  output logic        tickOut
);
  pwmStrobes_t strobes;

  burst_pwm_ctrl #(.ClkHz(ClkHz), .TickHz(TickHz)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrCode  (wrCode),
    .wrData  (wrData),
    .strobes (strobes),
    .enMask  (enableMask)
  );

  burst_pwm_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pwmOut  (pwmOut),
    .running (running)
  );

  assign tickOut = strobes.tick;

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (enableMask == 2'b00) |-> (pwmOut == 2'b00)); // R8
endmodule

// File: tb/test_burst_pwm_top.sv
module test_burst_pwm_top;
  localparam int ClkHz  = 100_000;
  localparam int TickHz = 10_000;
  localparam int Div    = ClkHz / TickHz;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrCode = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  pwmOut, running, enableMask;
  logic        tickOut;

  int errors = 0;
  int checks = 0;
  logic [1:0] maskShadow = 2'b00;

  always #10 clk = ~clk;

  burst_pwm_top #(.ClkHz(ClkHz), .TickHz(TickHz)) i_burst_pwm_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode), .wrData(wrData),
    .pwmOut(pwmOut), .running(running), .enableMask(enableMask), .tickOut(tickOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [7:0] code, input logic [15:0] data);
    wrEn = 1'b1; wrCode = code; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (code == 8'h1F) maskShadow = data[1:0];
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!tickOut);
  endtask

  function automatic int effP(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit expOut(int k, int hi, int lo, int burst);
    int per = effP(hi) + effP(lo);
    int cyc = k / per;
    return ((burst == 0) || (cyc < burst)) && ((k % per) < effP(hi));
  endfunction

  function automatic bit expRun(int k, int hi, int lo, int burst);
    return (burst == 0) || (k < burst * (effP(hi) + effP(lo)));
  endfunction

  task automatic configCh(input int ch, input int hi, input int lo, input int burst);
    writeReg(8'h1F, {14'd0, maskShadow & ~(2'b01 << ch)});
    writeReg(8'h10 + 8'(2 * ch), 16'(hi));
    writeReg(8'h11 + 8'(2 * ch), 16'(lo));
    writeReg(8'h14 + 8'(ch), 16'(burst));
  endtask

  task automatic testReset();
    check(pwmOut == 2'b00, "R8", "reset pwmOut", pwmOut, 0);
    check(running == 2'b00, "R8", "reset running", running, 0);
    check(enableMask == 2'b00, "R2", "reset mask", enableMask, 0);
  endtask

  task automatic testTick();
    int gap = 0;
    waitTick();
    @(negedge clk);
    check(tickOut == 1'b0, "R1", "tick width", tickOut, 0);
    gap = 1;
    while (!tickOut) begin @(negedge clk); gap++; end
    check(gap == Div, "R1", "tick spacing", gap, Div);
  endtask

  task automatic runOne(input int ch, input int hi, input int lo, input int burst,
                        input int nTicks, input string req);
    configCh(ch, hi, lo, burst);
    writeReg(8'h1F, {14'd0, maskShadow | (2'b01 << ch)});
    check(enableMask[ch] == 1'b1, "R2", "mask readback", enableMask[ch], 1);
    check(pwmOut[ch] && running[ch], "R3", "start high", {running[ch], pwmOut[ch]}, 3);
    for (int k = 0; k < nTicks; k++) begin
      waitTick();
      check(pwmOut[ch] == expOut(k, hi, lo, burst), req, $sformatf("ch%0d out tick %0d", ch, k),
            pwmOut[ch], expOut(k, hi, lo, burst));
      check(running[ch] == expRun(k, hi, lo, burst), req, $sformatf("ch%0d run tick %0d", ch, k),
            running[ch], expRun(k, hi, lo, burst));
    end
  endtask

  task automatic testBothChannels();
    configCh(0, 2, 1, 3);
    configCh(1, 1, 4, 0);
    writeReg(8'h1F, 16'h0003);
    check(enableMask == 2'b11, "R2", "both mask", enableMask, 3);
    check(pwmOut == 2'b11, "R10", "both start high", pwmOut, 3);
    for (int k = 0; k < 16; k++) begin
      waitTick();
      check(pwmOut[0] == expOut(k, 2, 1, 3), "R10", $sformatf("ch0 tick %0d", k),
            pwmOut[0], expOut(k, 2, 1, 3));
      check(pwmOut[1] == expOut(k, 1, 4, 0), "R10", $sformatf("ch1 tick %0d", k),
            pwmOut[1], expOut(k, 1, 4, 0));
    end
    writeReg(8'h1F, 16'h0000);
  endtask

  task automatic testRewriteMask();
    configCh(0, 3, 2, 0);
    writeReg(8'h1F, 16'h0001);
    for (int k = 0; k < 12; k++) begin
      waitTick();
      check(pwmOut[0] == expOut(k, 3, 2, 0), "R9", $sformatf("rewrite tick %0d", k),
            pwmOut[0], expOut(k, 3, 2, 0));
      if (k == 1 || k == 6) writeReg(8'h1F, 16'h0001);
    end
  endtask

  task automatic testDisableMid();
    configCh(1, 4, 4, 0);
    writeReg(8'h1F, {14'd0, maskShadow | 2'b10});
    waitTick();
    waitTick();
    check(pwmOut[1] == 1'b1, "R4", "still high before disable", pwmOut[1], 1);
    writeReg(8'h1F, {14'd0, maskShadow & 2'b01});
    check(pwmOut[1] == 1'b0 && running[1] == 1'b0, "R8", "disable mid-phase",
          {running[1], pwmOut[1]}, 0);
    check(enableMask[1] == 1'b0, "R2", "cleared mask", enableMask[1], 0);
    for (int k = 0; k < 6; k++) begin
      waitTick();
      check(pwmOut[1] == 1'b0, "R8", "disabled stays low", pwmOut[1], 0);
    end
  endtask

  task automatic testBurstStop();
    runOne(0, 2, 3, 2, 14, "R5");
    check(enableMask[0] == 1'b1, "R5", "mask kept after burst", enableMask[0], 1);
  endtask

  task automatic testRestart();
    runOne(0, 1, 2, 1, 5, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testTick();
    runOne(0, 3, 2, 2, 4, "R4");
    testBurstStop();
    testRestart();
    runOne(1, 2, 2, 0, 20, "R6");
    runOne(1, 0, 0, 2, 7, "R7");
    testBothChannels();
    testRewriteMask();
    testDisableMid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule